// File: doc/BRIEF.md
# Wiper and Data Register Bank

This block is the register core of a four-channel digital potentiometer controller. It holds one volatile wiper register for each of the four channels, a grid of data registers arranged as four levels with one register per channel at each level, and a small status register. A bus front end reaches it through a plain internal register port: an address, a write strobe, a read strobe, write data and registered read data. The four wiper values are driven out continuously to the analog side.

Access to channel addresses 0 to 3 is steered by the status register rather than by the address alone. With the nonvolatile-select bit clear, a channel address reaches that channel's wiper register. With the bit set, it reaches the data register of that channel at the level held in the status register. Selecting a level, writing a data register and reading a data register all move data from that level into the wiper registers as a side effect. Data-register writes are first held in a staging buffer and become permanent only when the front end pulses a commit strobe, which it does at the end of a bus transaction. A committed write raises a busy flag for a fixed number of cycles that models the storage write time. No access is accepted while the flag is up.

Top module: `wiper_bank`

## Requirements
- R1: While reset is held, and directly after it, every wiper output, every data register, the status register and `rdata_o` are 00h and `busy_o` is low.
- R2: The status register is at address 7. Bit 0 is the nonvolatile select (NV), bits 2:1 are the level (0 to 3), and bits 7:3 always read back as 0, whatever was written.
- R3: `wiper_o` carries channel slot k (address k) in bits [8k+7:8k]. With NV = 0, a write to address k sets only that wiper, and a read of address k returns that wiper.
- R4: A status write with bit 0 set loads all four wipers from the data registers of the level given in bits 2:1 of the written byte, at the same clock edge.
- R5: With NV = 1, a write to address k stages the byte for data register k of the current level and puts it in wiper k at once. The other three wipers take that level's values, with any byte still staged for a channel taking the place of its stored value. The stored data register does not change until commit.
- R6: A commit with `wp_n_i` high and at least one staged byte copies every staged byte into its data register, clears the stage, and holds `busy_o` high for exactly BUSY_CYCLES cycles, starting in the cycle after the commit edge.
- R7: A commit with `wp_n_i` low discards the staged bytes, leaves the data registers unchanged and does not raise `busy_o`.
- R8: With NV = 1, a read of address k returns the data register value of the current level (a staged byte if one is pending) on `rdata_o` one cycle later, and loads that value into wiper k.
- R9: Reads of addresses 4 to 6 return 00h. Writes to them change no wiper and no status bit.
- R10: While `busy_o` is high, writes and commits are ignored and a read returns 00h.
- R11: A status write discards any staged bytes, so a later commit finds nothing to store and does not raise `busy_o`.
- R12: Writing the same channel twice before a commit keeps only the later byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Register address: 0 to 3 channel slots, 7 status |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access; ignored when a write is in the same cycle |
| wdata_i | input | DW | Write data |
| commit_i | input | 1 | End-of-transaction strobe that commits staged data-register bytes |
| wp_n_i | input | 1 | Write protect, active low, sampled at commit |
| rdata_o | output | DW | Registered read data, updated the cycle after a read |
| wiper_o | output | NW*DW | The four wiper values, slot k in bits [DW*k+DW-1:DW*k] |
| busy_o | output | 1 | High while a committed write is being stored |

## Verification
The bench builds the block with its defaults: four channels, four levels, 8-bit data and a four-cycle busy window. That short window lets the bench count every busy cycle one at a time and still place a read and a status write inside it. With four levels it can move between levels 0, 1 and 2 and see that untouched levels still load zeros into the wipers. With four channels a page of staged bytes can mix staged and stored values in one row transfer, and the unused addresses 4 to 6 can be checked.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;
  localparam int STATUS_ADDR = 7;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_STATUS_WR,
    ACC_STATUS_RD,
    ACC_WIPER_WR,
    ACC_WIPER_RD,
    ACC_DATA_WR,
    ACC_DATA_RD,
    ACC_VOID_RD,
    ACC_BUSY_RD,
    ACC_COMMIT
  } acc_kind_e;
endpackage

// File: rtl/wiper_bank_decode.sv
module wiper_bank_decode
  import wiper_bank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NW     = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              commit_i,
  input  logic              busy_i,
  input  logic              nv_i,
  output acc_kind_e         kind_o
);
  logic is_status;
  logic is_slot;

  assign is_status = (addr_i == ADDR_W'(STATUS_ADDR));
  assign is_slot   = (addr_i < ADDR_W'(NW));

  always_comb begin
    kind_o = ACC_NONE;
    if (busy_i) begin
      if (rd_en_i && !wr_en_i) kind_o = ACC_BUSY_RD;
    end else if (commit_i) begin
      kind_o = ACC_COMMIT;
    end else if (wr_en_i) begin
      if (is_status)    kind_o = ACC_STATUS_WR;
      else if (is_slot) kind_o = nv_i ? ACC_DATA_WR : ACC_WIPER_WR;
    end else if (rd_en_i) begin
      if (is_status)    kind_o = ACC_STATUS_RD;
      else if (is_slot) kind_o = nv_i ? ACC_DATA_RD : ACC_WIPER_RD;
      else              kind_o = ACC_VOID_RD;
    end
  end
endmodule

// File: rtl/wiper_bank_stage.sv
module wiper_bank_stage #(
  parameter int DW = 8,
  parameter int NW = 4,
  localparam int SLOT_W = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DW-1:0]     data_i,
  output logic [NW-1:0]     vld_o,
  output logic [NW*DW-1:0]  val_o
);
  for (genvar g = 0; g < NW; g++) begin : g_entry
    logic          vld_q, vld_d, en;
    logic [DW-1:0] val_q;
    logic          hit;

    assign hit   = wr_i && (slot_i == SLOT_W'(g));
    assign en    = clr_i || hit;
    assign vld_d = !clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        val_q <= '0;
      end else begin
        if (en)            vld_q <= vld_d;
        if (hit && !clr_i) val_q <= data_i;
      end
    end

    assign vld_o[g]           = vld_q;
    assign val_o[g*DW +: DW]  = val_q;
  end
endmodule

// File: rtl/wiper_bank_busy.sv
module wiper_bank_busy #(
  parameter int BUSY_CYCLES = 4,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_bank_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NW          = 4,
  parameter int NL          = 4,
  parameter int BUSY_CYCLES = 4,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              commit_i,
  input  logic              wp_n_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NW*DW-1:0]  wiper_o,
  output logic              busy_o
);
  localparam int SLOT_W = $clog2(NW);
  localparam int LVL_W  = $clog2(NL);
  localparam int STAT_W = 1 + LVL_W;

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [STAT_W-1:0] status_q, status_d;
  logic [DW-1:0]     wiper_q [NW];
  logic [DW-1:0]     wiper_d [NW];
  logic [DW-1:0]     dr_q    [NL][NW];
  logic [DW-1:0]     dr_d    [NL][NW];
  logic [DW-1:0]     rdata_q, rdata_d;
  logic [DW-1:0]     eff     [NW];

  logic [NW-1:0]     stg_vld;
  logic [NW*DW-1:0]  stg_val;
  logic              stg_clr, stg_wr, busy_start;
  acc_kind_e         kind;

  logic [LVL_W-1:0]  lvl;
  logic [LVL_W-1:0]  new_lvl;
  logic [SLOT_W-1:0] slot;
  logic              nv;

  assign nv      = status_q[0];
  assign lvl     = status_q[LVL_W:1];
  assign new_lvl = wdata_i[LVL_W:1];
  assign slot    = addr_i[SLOT_W-1:0];

  wiper_bank_decode #(.ADDR_W(ADDR_W), .NW(NW)) u_decode (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .commit_i (commit_i),
    .busy_i   (busy_o),
    .nv_i     (nv),
    .kind_o   (kind)
  );

  wiper_bank_stage #(.DW(DW), .NW(NW)) u_stage (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (stg_clr),
    .wr_i   (stg_wr),
    .slot_i (slot),
    .data_i (wdata_i),
    .vld_o  (stg_vld),
    .val_o  (stg_val)
  );

  wiper_bank_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (busy_start),
    .busy_o  (busy_o)
  );

  // current-level view: staged byte wins over the stored one
  always_comb begin
    for (int j = 0; j < NW; j++)
      eff[j] = stg_vld[j] ? stg_val[j*DW +: DW] : dr_q[lvl][j];
  end

  // next-state logic
  always_comb begin
    status_d   = status_q;
    rdata_d    = rdata_q;
    wiper_d    = wiper_q;
    dr_d       = dr_q;
    stg_clr    = 1'b0;
    stg_wr     = 1'b0;
    busy_start = 1'b0;
    unique case (kind)
      ACC_STATUS_WR: begin
        status_d = wdata_i[STAT_W-1:0];
        stg_clr  = 1'b1;
        if (wdata_i[0])
          for (int j = 0; j < NW; j++) wiper_d[j] = dr_q[new_lvl][j];
      end
      ACC_STATUS_RD: rdata_d = {{(DW-STAT_W){1'b0}}, status_q};
      ACC_WIPER_WR:  wiper_d[slot] = wdata_i;
      ACC_WIPER_RD:  rdata_d = wiper_q[slot];
      ACC_DATA_WR: begin
        stg_wr = 1'b1;
        for (int j = 0; j < NW; j++)
          wiper_d[j] = (slot == SLOT_W'(j)) ? wdata_i : eff[j];
      end
      ACC_DATA_RD: begin
        rdata_d       = eff[slot];
        wiper_d[slot] = eff[slot];
      end
      ACC_VOID_RD, ACC_BUSY_RD: rdata_d = '0;
      ACC_COMMIT: begin
        stg_clr = 1'b1;
        if (wp_n_i && (|stg_vld)) begin
          busy_start = 1'b1;
          for (int j = 0; j < NW; j++)
            if (stg_vld[j]) dr_d[lvl][j] = stg_val[j*DW +: DW];
        end
      end
      default: ;
    endcase
  end

  // state registers with explicit enables
  logic status_en, rdata_en, dr_en;
  assign status_en = (kind == ACC_STATUS_WR);
  assign rdata_en  = (kind == ACC_STATUS_RD) || (kind == ACC_WIPER_RD) ||
                     (kind == ACC_DATA_RD) || (kind == ACC_VOID_RD) ||
                     (kind == ACC_BUSY_RD);
  assign dr_en     = busy_start;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q <= '0;
      rdata_q  <= '0;
      for (int j = 0; j < NW; j++) wiper_q[j] <= '0;
      for (int l = 0; l < NL; l++)
        for (int j = 0; j < NW; j++) dr_q[l][j] <= '0;
    end else begin
      if (status_en) status_q <= status_d;
      if (rdata_en)  rdata_q  <= rdata_d;
      for (int j = 0; j < NW; j++) wiper_q[j] <= wiper_d[j];
      if (dr_en) dr_q <= dr_d;
    end
  end

  assign rdata_o = rdata_q;
  for (genvar g = 0; g < NW; g++) begin : g_out
    assign wiper_o[g*DW +: DW] = wiper_q[g];
  end
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int DW     = 8,
  parameter int NW     = 4,
  parameter int ADDR_W = 3,
  parameter int STAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              commit_i,
  input logic              wp_n_i,
  input logic              busy_o,
  input logic [DW-1:0]     rdata_o,
  input logic [NW*DW-1:0]  wiper_o,
  input logic [STAT_W-1:0] status_q,
  input logic [NW-1:0]     stg_vld
);
  localparam int SLOT_W = $clog2(NW);
  logic ok;
  assign ok = !busy_o && !commit_i;

  assert_busy_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(status_q) && $stable(wiper_o)));

  assert_unused_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && wr_en_i && addr_i >= ADDR_W'(NW) && addr_i != ADDR_W'(7))
      |=> ($stable(wiper_o) && $stable(status_q)));

  assert_protected_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !wp_n_i && !busy_o) |=> !busy_o);

  assert_commit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && wp_n_i && (|stg_vld) && !busy_o) |=> busy_o);

  assert_status_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && rd_en_i && !wr_en_i && addr_i == ADDR_W'(7))
      |=> (rdata_o[DW-1:STAT_W] == '0));

  assert_single_wiper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && wr_en_i && addr_i == '0 && !status_q[0])
      |=> $stable(wiper_o[NW*DW-1:DW]));

  assert_read_loads_wiper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && rd_en_i && !wr_en_i && addr_i < ADDR_W'(NW) && status_q[0])
      |=> (rdata_o == wiper_o[$past(addr_i[SLOT_W-1:0])*DW +: DW]));
endmodule

bind wiper_bank wiper_bank_chk #(.DW(DW), .NW(NW), .ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .commit_i (commit_i),
  .wp_n_i   (wp_n_i),
  .busy_o   (busy_o),
  .rdata_o  (rdata_o),
  .wiper_o  (wiper_o),
  .status_q (status_q),
  .stg_vld  (stg_vld)
);

// File: tb/tb_wiper_bank.sv
module tb_wiper_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, NW = 4, NL = 4, BUSY_CYCLES = 4, ADDR_W = 3;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CM = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [7:0]  data;
    logic        wp;
    logic        chk_rd;
    logic [7:0]  exp_rd;
    logic [31:0] exp_w;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{OP_WR, 3'd0, 8'h11, 1'b1, 1'b0, 8'h00, 32'h00_00_00_11}, // R3
    '{OP_WR, 3'd3, 8'h44, 1'b1, 1'b0, 8'h00, 32'h44_00_00_11}, // R3
    '{OP_RD, 3'd3, 8'h00, 1'b1, 1'b1, 8'h44, 32'h44_00_00_11}, // R3
    '{OP_WR, 3'd7, 8'h01, 1'b1, 1'b0, 8'h00, 32'h00_00_00_00}, // R4 level 0
    '{OP_WR, 3'd1, 8'hA1, 1'b1, 1'b0, 8'h00, 32'h00_00_A1_00}, // R5
    '{OP_WR, 3'd2, 8'hB2, 1'b1, 1'b0, 8'h00, 32'h00_B2_A1_00}, // R5 staged kept
    '{OP_RD, 3'd1, 8'h00, 1'b1, 1'b1, 8'hA1, 32'h00_B2_A1_00}, // R8 staged
    '{OP_CM, 3'd0, 8'h00, 1'b1, 1'b0, 8'h00, 32'h00_B2_A1_00}, // R6
    '{OP_WR, 3'd7, 8'h03, 1'b1, 1'b0, 8'h00, 32'h00_00_00_00}, // R4 level 1
    '{OP_WR, 3'd7, 8'h01, 1'b1, 1'b0, 8'h00, 32'h00_B2_A1_00}, // R4/R6 level 0
    '{OP_WR, 3'd0, 8'h5A, 1'b1, 1'b0, 8'h00, 32'h00_B2_A1_5A}, // R5 row copy
    '{OP_CM, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 32'h00_B2_A1_5A}, // R7
    '{OP_RD, 3'd0, 8'h00, 1'b1, 1'b1, 8'h00, 32'h00_B2_A1_00}, // R7/R8
    '{OP_WR, 3'd5, 8'hFF, 1'b1, 1'b0, 8'h00, 32'h00_B2_A1_00}, // R9
    '{OP_RD, 3'd5, 8'h00, 1'b1, 1'b1, 8'h00, 32'h00_B2_A1_00}, // R9
    '{OP_RD, 3'd7, 8'h00, 1'b1, 1'b1, 8'h01, 32'h00_B2_A1_00}, // R2
    '{OP_WR, 3'd7, 8'hFA, 1'b1, 1'b0, 8'h00, 32'h00_B2_A1_00}, // R2 no load
    '{OP_RD, 3'd7, 8'h00, 1'b1, 1'b1, 8'h02, 32'h00_B2_A1_00}, // R2 reserved 0
    '{OP_WR, 3'd2, 8'h77, 1'b1, 1'b0, 8'h00, 32'h00_77_A1_00}  // R3 NV=0
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_i;
  logic              wr_en_i, rd_en_i, commit_i, wp_n_i;
  logic [DW-1:0]     wdata_i;
  logic [DW-1:0]     rdata_o;
  logic [NW*DW-1:0]  wiper_o;
  logic              busy_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_bank #(.DW(DW), .NW(NW), .NL(NL), .BUSY_CYCLES(BUSY_CYCLES), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wdata_i(wdata_i), .commit_i(commit_i), .wp_n_i(wp_n_i),
    .rdata_o(rdata_o), .wiper_o(wiper_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one access: driven at a falling edge, applied at the next rising edge,
  // returns at the following falling edge; a commit also waits out busy
  task automatic run_op(input logic [1:0] op, input logic [2:0] a,
                        input logic [7:0] d, input logic wp);
    addr_i   = a;
    wdata_i  = d;
    wp_n_i   = wp;
    wr_en_i  = (op == OP_WR);
    rd_en_i  = (op == OP_RD);
    commit_i = (op == OP_CM);
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0; commit_i = 1'b0; wp_n_i = 1'b1;
    if (op == OP_CM) begin
      for (int k = 0; k < 50 && busy_o; k++) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr_i = '0; wdata_i = '0;
    wr_en_i = 1'b0; rd_en_i = 1'b0; commit_i = 1'b0; wp_n_i = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 wipers", wiper_o, 32'h0);
    check("R1 rdata", {24'h0, rdata_o}, 32'h0);
    check("R1 busy", {31'h0, busy_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 wipers after release", wiper_o, 32'h0);
    run_op(OP_RD, 3'd7, 8'h00, 1'b1);
    check("R1 status", {24'h0, rdata_o}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      run_op(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].wp);
      check($sformatf("vector %0d wipers (R3-R9)", i), wiper_o, VECS[i].exp_w);
      if (VECS[i].chk_rd)
        check($sformatf("vector %0d rdata (R2/R3/R8/R9)", i), {24'h0, rdata_o}, {24'h0, VECS[i].exp_rd});
    end

    // R6 / R10: busy window length and ignored accesses inside it
    run_op(OP_WR, 3'd7, 8'h05, 1'b1);           // level 2, NV
    check("R4 level 2 load", wiper_o, 32'h0);
    run_op(OP_WR, 3'd3, 8'h33, 1'b1);
    check("R5 stage slot 3", wiper_o, 32'h33_00_00_00);
    commit_i = 1'b1; wp_n_i = 1'b1;
    @(posedge clk); @(negedge clk);
    commit_i = 1'b0;
    check("R6 busy cycle 1", {31'h0, busy_o}, 32'h1);
    rd_en_i = 1'b1; addr_i = 3'd7;
    @(posedge clk); @(negedge clk);
    rd_en_i = 1'b0;
    check("R10 read while busy", {24'h0, rdata_o}, 32'h0);
    check("R6 busy cycle 2", {31'h0, busy_o}, 32'h1);
    wr_en_i = 1'b1; addr_i = 3'd7; wdata_i = 8'h00;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
    check("R6 busy cycle 3", {31'h0, busy_o}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R6 busy cycle 4", {31'h0, busy_o}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R6 busy ends", {31'h0, busy_o}, 32'h0);
    run_op(OP_RD, 3'd7, 8'h00, 1'b1);
    check("R10 status write ignored", {24'h0, rdata_o}, 32'h05);
    run_op(OP_RD, 3'd3, 8'h00, 1'b1);
    check("R6 committed byte", {24'h0, rdata_o}, 32'h33);

    // R11: status write drops staged bytes
    run_op(OP_WR, 3'd0, 8'h99, 1'b1);
    check("R5 stage slot 0", wiper_o, 32'h33_00_00_99);
    run_op(OP_WR, 3'd7, 8'h05, 1'b1);
    check("R11 reload level 2", wiper_o, 32'h33_00_00_00);
    commit_i = 1'b1; wp_n_i = 1'b1;
    @(posedge clk); @(negedge clk);
    commit_i = 1'b0;
    check("R11 empty commit no busy", {31'h0, busy_o}, 32'h0);
    run_op(OP_RD, 3'd0, 8'h00, 1'b1);
    check("R11 slot 0 unchanged", {24'h0, rdata_o}, 32'h0);

    // R12: second write to a slot replaces the staged byte
    run_op(OP_WR, 3'd1, 8'h10, 1'b1);
    run_op(OP_WR, 3'd1, 8'h20, 1'b1);
    check("R12 wiper holds later byte", wiper_o, 32'h33_00_20_00);
    run_op(OP_CM, 3'd0, 8'h00, 1'b1);
    run_op(OP_WR, 3'd7, 8'h03, 1'b1);
    check("R4 level 1 still empty", wiper_o, 32'h0);
    run_op(OP_WR, 3'd7, 8'h05, 1'b1);
    check("R12 level 2 row", wiper_o, 32'h33_00_20_00);
    run_op(OP_RD, 3'd1, 8'h00, 1'b1);
    check("R12 stored later byte", {24'h0, rdata_o}, 32'h20);

    finish_run();
  end
endmodule